// File: doc/BRIEF.md
# Software-Loaded Translation Buffer

This block is a fully associative translation buffer that software owns entirely. Each entry pairs a tag word with a translation word. Bit 63 of the translation word marks the entry as valid, and bit 6 marks it as locked. Nothing inside the block walks page tables. Software loads entries one request at a time through a single register-style port.

To load an entry, software first writes the tag it wants into the tag-staging register. It then issues one of two writes:
- a self-placing fill, where the block picks the victim entry;
- an indexed write, where the request address names the entry.

Software can also:
- query the buffer associatively by tag;
- flush every entry at once;
- read and write a small translation-enable register and a fault-status register.

Every request gets exactly one registered response on the next cycle. A request from unprivileged code in a protected address space is refused with a fault response instead of taking effect.

Victim choice for the self-placing fill is fixed:
1. The lowest-numbered invalid entry.
2. Failing that, the lowest-numbered unlocked entry.
3. If every entry is valid and locked, the write is discarded without any indication.

Top module: `xlate_buf`

## Requirements
- R1: After reset every entry is invalid, and the tag-staging, enable and status registers read zero. No response is presented while reset is applied.
- R2: Each request with `req_valid` high produces `rsp_valid` high on exactly the following cycle, and no response appears otherwise. The operation codes on `req_op` are:
  - 0: tag-staging write
  - 1: tag-staging read
  - 2: enable write
  - 3: enable read
  - 4: status write
  - 5: status read
  - 6: self-placing fill
  - 7: indexed write
  - 8: tag query
  - 9: flush
  
  Writes, fills and flushes return zero data. Codes 10 to 15 return zero and change nothing.
- R3: A request made with `priv_mode` low and `req_space` below 0x80 returns `rsp_fault` high with zero data, and leaves all state unchanged. A space of 0x80 or above is accepted without privilege.
- R4: A tag-staging write stores the full 64-bit data word, and a tag-staging read returns it.
- R5: A self-placing fill writes the lowest-index entry whose bit 63 is clear. The entry's tag comes from the tag-staging register and its translation word from `req_wdata`.
- R6: When every entry is valid, a self-placing fill replaces the lowest-index entry whose bit 6 is clear.
- R7: When every entry is both valid and locked, a self-placing fill changes no entry.
- R8: An indexed write replaces the entry numbered by `req_addr[8:3]`. It takes the tag from the tag-staging register and the translation word from `req_wdata`, whatever the state of that entry.
- R9: A tag query compares `req_wdata` against the stored tags. It returns the tag of the lowest-index valid entry whose tag equals the query, or zero if there is no such entry. Invalid entries never match.
- R10: A flush clears bit 63 of every entry in a single cycle.
- R11: An enable write keeps bits 1:0 of the data. If the kept value differs from the current one, all entries are invalidated in that cycle; an equal value leaves the entries untouched.
- R12: A status write whose bit 0 is clear sets the status register to zero. Otherwise the register takes the whole data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_op | input | 4 | Operation code (see R2) |
| req_space | input | 8 | Address-space identifier used for the privilege gate |
| req_addr | input | 16 | Request address; bits 8:3 select the entry for an indexed write |
| req_wdata | input | 64 | Write data, or the query tag for a tag query |
| priv_mode | input | 1 | High when the requester is privileged |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 64 | Response data |
| rsp_fault | output | 1 | Privilege fault on the answered request |

## Verification
The bench builds the block with its default parameters: 64 entries, 64-bit tag and translation words, and the entry index taken from address bits 8:3. With 64 entries, a few hundred requests are enough to fill the buffer completely and punch holes in it. They also reach the full-but-unlocked replacement case, the all-locked drop, and the top index 63. Expected responses for each request are computed by the bench from the requirements and queued. They are compared in order as responses emerge, including the privilege boundary at space 0x80 and the enable-write cases with equal and unequal values.

// File: rtl/xb_pkg.sv
package xb_pkg;

  typedef enum logic [3:0] {
    OP_TAG_WR  = 4'd0,
    OP_TAG_RD  = 4'd1,
    OP_CTL_WR  = 4'd2,
    OP_CTL_RD  = 4'd3,
    OP_STS_WR  = 4'd4,
    OP_STS_RD  = 4'd5,
    OP_FILL    = 4'd6,
    OP_IDX_WR  = 4'd7,
    OP_LOOKUP  = 4'd8,
    OP_FLUSH   = 4'd9
  } xb_op_e;

endpackage

// File: rtl/xb_regs.sv
module xb_regs #(
  parameter int WORD_W = 64,
  parameter int CTL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tag_we,
  input  logic              ctl_we,
  input  logic              sts_we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] tag_q,
  output logic [CTL_W-1:0]  ctl_q,
  output logic [WORD_W-1:0] sts_q,
  output logic              ctl_changed
);

  logic [WORD_W-1:0] tag_d;
  logic [CTL_W-1:0]  ctl_d;
  logic [WORD_W-1:0] sts_d;

  always_comb begin
    tag_d = wdata;
    ctl_d = wdata[CTL_W-1:0];
    if (wdata[0]) sts_d = wdata;
    else          sts_d = '0;
  end

  assign ctl_changed = ctl_we && (wdata[CTL_W-1:0] != ctl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tag_q <= '0;
    else if (tag_we) tag_q <= tag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (sts_we) sts_q <= sts_d;
  end

  // R12: a status write with bit 0 clear leaves the register at zero
  a_r12_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_we && !wdata[0]) |=> (sts_q == '0));

  // R4: the staged tag holds exactly the written word
  a_r4_tag_stage: assert property (@(posedge clk) disable iff (!rst_n)
    tag_we |=> (tag_q == $past(wdata)));

  // R11: the enable register keeps only the low bits of the data
  a_r11_ctl_keep: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (ctl_q == $past(wdata[CTL_W-1:0])));

endmodule

// File: rtl/xb_store.sv
module xb_store #(
  parameter int ENTRIES   = 64,
  parameter int WORD_W    = 64,
  parameter int VALID_BIT = 63,
  parameter int LOCK_BIT  = 6,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [WORD_W-1:0]               wr_tag,
  input  logic [WORD_W-1:0]               wr_data,
  input  logic                            inval_all,
  output logic [ENTRIES-1:0]              valid_vec,
  output logic [ENTRIES-1:0]              lock_vec,
  output logic [ENTRIES-1:0][WORD_W-1:0]  tags
);

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_ent
    logic [WORD_W-1:0] ent_tag_q, ent_tag_d;
    logic [WORD_W-1:0] ent_dat_q, ent_dat_d;
    logic              ent_sel;
    logic              ent_en;

    assign ent_sel = wr_en && (wr_idx == IDX_W'(gi));
    assign ent_en  = inval_all || ent_sel;

    always_comb begin
      ent_tag_d = ent_tag_q;
      ent_dat_d = ent_dat_q;
      if (inval_all) begin
        ent_dat_d[VALID_BIT] = 1'b0;
      end else if (ent_sel) begin
        ent_tag_d = wr_tag;
        ent_dat_d = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_tag_q <= '0;
        ent_dat_q <= '0;
      end else if (ent_en) begin
        ent_tag_q <= ent_tag_d;
        ent_dat_q <= ent_dat_d;
      end
    end

    assign tags[gi]      = ent_tag_q;
    assign valid_vec[gi] = ent_dat_q[VALID_BIT];
    assign lock_vec[gi]  = ent_dat_q[LOCK_BIT];
  end

  // R10: a flush leaves no valid entry behind
  a_r10_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
    inval_all |=> (valid_vec == '0));

  // R8: a written entry carries the supplied tag afterwards
  a_r8_entry_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !inval_all) |=> (tags[$past(wr_idx)] == $past(wr_tag)));

endmodule

// File: rtl/xb_victim.sv
module xb_victim #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] lock_vec,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);

  logic             inv_hit, unl_hit;
  logic [IDX_W-1:0] inv_idx, unl_idx;

  always_comb begin
    inv_hit = 1'b0;
    unl_hit = 1'b0;
    inv_idx = '0;
    unl_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        inv_hit = 1'b1;
        inv_idx = IDX_W'(i);
      end
      if (!lock_vec[i]) begin
        unl_hit = 1'b1;
        unl_idx = IDX_W'(i);
      end
    end
  end

  assign found = inv_hit || unl_hit;
  assign idx   = inv_hit ? inv_idx : unl_idx;

  // R5: any invalid entry takes precedence over unlocked ones
  a_r5_prefer_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_vec != '1) |-> !valid_vec[idx]);

  // R6: the chosen victim is never valid and locked at once
  a_r6_victim_free: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (!valid_vec[idx] || !lock_vec[idx]));

  // R7: no victim only when every entry is valid and locked
  a_r7_none_free: assert property (@(posedge clk) disable iff (!rst_n)
    !found |-> ((valid_vec & lock_vec) == '1));

endmodule

// File: rtl/xb_search.sv
module xb_search #(
  parameter int ENTRIES = 64,
  parameter int WORD_W  = 64
) (
  input  logic [ENTRIES-1:0]             valid_vec,
  input  logic [ENTRIES-1:0][WORD_W-1:0] tags,
  input  logic [WORD_W-1:0]              query,
  output logic                           hit,
  output logic [WORD_W-1:0]              hit_tag
);

  logic [ENTRIES-1:0] match;

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
    assign match[gi] = valid_vec[gi] && (tags[gi] == query);
  end

  always_comb begin
    hit     = 1'b0;
    hit_tag = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_tag = tags[i];
      end
    end
  end

endmodule

// File: rtl/xlate_buf.sv
module xlate_buf
  import xb_pkg::*;
#(
  parameter int ENTRIES        = 64,
  parameter int WORD_W         = 64,
  parameter int ADDR_W         = 16,
  parameter int IDX_LSB        = 3,
  parameter int VALID_BIT      = 63,
  parameter int LOCK_BIT       = 6,
  parameter int CTL_W          = 2,
  parameter int SPACE_W        = 8,
  parameter int SPACE_OPEN_MIN = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [3:0]         req_op,
  input  logic [SPACE_W-1:0] req_space,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [WORD_W-1:0]  req_wdata,
  input  logic               priv_mode,
  output logic               rsp_valid,
  output logic [WORD_W-1:0]  rsp_rdata,
  output logic               rsp_fault
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [SPACE_W-1:0] OPEN_MIN = SPACE_W'(SPACE_OPEN_MIN);

  xb_op_e op;
  logic   allowed, go;
  logic   tag_we, ctl_we, sts_we, fill_go, idx_go, flush_go;

  assign op      = xb_op_e'(req_op);
  assign allowed = priv_mode || (req_space >= OPEN_MIN);
  assign go      = req_valid && allowed;

  assign tag_we   = go && (op == OP_TAG_WR);
  assign ctl_we   = go && (op == OP_CTL_WR);
  assign sts_we   = go && (op == OP_STS_WR);
  assign fill_go  = go && (op == OP_FILL);
  assign idx_go   = go && (op == OP_IDX_WR);
  assign flush_go = go && (op == OP_FLUSH);

  logic [WORD_W-1:0] tag_q, sts_q;
  logic [CTL_W-1:0]  ctl_q;
  logic              ctl_changed;

  xb_regs #(.WORD_W(WORD_W), .CTL_W(CTL_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .tag_we      (tag_we),
    .ctl_we      (ctl_we),
    .sts_we      (sts_we),
    .wdata       (req_wdata),
    .tag_q       (tag_q),
    .ctl_q       (ctl_q),
    .sts_q       (sts_q),
    .ctl_changed (ctl_changed)
  );

  logic [ENTRIES-1:0]             valid_vec, lock_vec;
  logic [ENTRIES-1:0][WORD_W-1:0] tags;
  logic                           vic_found;
  logic [IDX_W-1:0]               vic_idx;

  xb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_vec (valid_vec),
    .lock_vec  (lock_vec),
    .found     (vic_found),
    .idx       (vic_idx)
  );

  logic             wr_en, inval_all;
  logic [IDX_W-1:0] wr_idx;

  assign wr_en     = (fill_go && vic_found) || idx_go;
  assign wr_idx    = fill_go ? vic_idx : req_addr[IDX_LSB +: IDX_W];
  assign inval_all = flush_go || ctl_changed;

  xb_store #(
    .ENTRIES   (ENTRIES),
    .WORD_W    (WORD_W),
    .VALID_BIT (VALID_BIT),
    .LOCK_BIT  (LOCK_BIT)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_tag    (tag_q),
    .wr_data   (req_wdata),
    .inval_all (inval_all),
    .valid_vec (valid_vec),
    .lock_vec  (lock_vec),
    .tags      (tags)
  );

  logic              q_hit;
  logic [WORD_W-1:0] q_tag;

  xb_search #(.ENTRIES(ENTRIES), .WORD_W(WORD_W)) u_search (
    .valid_vec (valid_vec),
    .tags      (tags),
    .query     (req_wdata),
    .hit       (q_hit),
    .hit_tag   (q_tag)
  );

  logic [WORD_W-1:0] rdata_d;
  logic              fault_d;

  always_comb begin
    rdata_d = '0;
    fault_d = req_valid && !allowed;
    if (go) begin
      case (op)
        OP_TAG_RD: rdata_d = tag_q;
        OP_CTL_RD: rdata_d = WORD_W'(ctl_q);
        OP_STS_RD: rdata_d = sts_q;
        OP_LOOKUP: rdata_d = q_hit ? q_tag : '0;
        default:   rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
      rsp_fault <= 1'b0;
    end else if (req_valid) begin
      rsp_rdata <= rdata_d;
      rsp_fault <= fault_d;
    end
  end

  // R2: one response per request, on the next cycle
  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R3: unprivileged access to a protected space faults with zero data
  a_r3_priv_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !priv_mode && (req_space < OPEN_MIN))
      |=> (rsp_fault && (rsp_rdata == '0)));

  // R3: a refused request leaves the entries alone
  a_r3_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !allowed) |=> ($stable(valid_vec) && $stable(lock_vec)));

  // R7: a fill with no free victim changes no entry
  a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && !vic_found) |=> ($stable(valid_vec) && $stable(lock_vec)));

endmodule

// File: tb/sim_xlate_buf.sv
module sim_xlate_buf;

  localparam logic [3:0] C_TAG_WR = 4'd0, C_TAG_RD = 4'd1, C_CTL_WR = 4'd2,
                         C_CTL_RD = 4'd3, C_STS_WR = 4'd4, C_STS_RD = 4'd5,
                         C_FILL   = 4'd6, C_IDX_WR = 4'd7, C_LOOKUP = 4'd8,
                         C_FLUSH  = 4'd9;
  localparam logic [63:0] V = 64'h8000_0000_0000_0000;
  localparam logic [63:0] L = 64'h40;

  logic        clk, rst_n;
  logic        req_valid;
  logic [3:0]  req_op;
  logic [7:0]  req_space;
  logic [15:0] req_addr;
  logic [63:0] req_wdata;
  logic        priv_mode;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        rsp_fault;

  xlate_buf u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_space(req_space), .req_addr(req_addr), .req_wdata(req_wdata),
    .priv_mode(priv_mode), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_fault(rsp_fault)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic [63:0] d;
    logic        f;
    string       r;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  logic cur_priv  = 1'b1;
  logic [7:0] cur_space = 8'h58;

  task automatic issue(input logic [3:0] op, input logic [63:0] wd,
                       input logic [15:0] ad, input logic [63:0] ed,
                       input logic ef, input string tg);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_wdata = wd;
    req_addr  = ad;
    req_space = cur_space;
    priv_mode = cur_priv;
    e.d = ed; e.f = ef; e.r = tg;
    q.push_back(e);
  endtask

  task automatic wr(input logic [3:0] op, input logic [63:0] wd);
    issue(op, wd, 16'h0, 64'h0, 1'b0, "R2 write response");
  endtask

  task automatic rd(input logic [3:0] op, input logic [63:0] ed, input string tg);
    issue(op, 64'h0, 16'h0, ed, 1'b0, tg);
  endtask

  task automatic look(input logic [63:0] qt, input logic [63:0] ed, input string tg);
    issue(C_LOOKUP, qt, 16'h0, ed, 1'b0, tg);
  endtask

  task automatic idx_put(input int i, input logic [63:0] tg, input logic [63:0] dat);
    wr(C_TAG_WR, tg);
    issue(C_IDX_WR, dat, 16'(i << 3), 64'h0, 1'b0, "R8 indexed write");
  endtask

  task automatic fill(input logic [63:0] tg, input logic [63:0] dat);
    wr(C_TAG_WR, tg);
    wr(C_FILL, dat);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R2 response with nothing outstanding: data %h expected none", rsp_rdata);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (rsp_rdata !== e.d || rsp_fault !== e.f) begin
          errors++;
          $display("FAIL %s: data %h fault %b, expected data %h fault %b",
                   e.r, rsp_rdata, rsp_fault, e.d, e.f);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    req_valid = 1'b0; req_op = '0; req_space = '0; req_addr = '0;
    req_wdata = '0; priv_mode = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 rsp_valid during reset: %b expected 0", rsp_valid);
    end
    rst_n = 1'b1;

    // R1 reset state
    rd(C_TAG_RD, 64'h0, "R1 tag register after reset");
    rd(C_CTL_RD, 64'h0, "R1 enable register after reset");
    rd(C_STS_RD, 64'h0, "R1 status register after reset");
    look(64'h0, 64'h0, "R1 entries invalid after reset");

    // R4 staging register
    wr(C_TAG_WR, 64'hFEDC_BA98_0000_1000);
    rd(C_TAG_RD, 64'hFEDC_BA98_0000_1000, "R4 tag register readback");

    // R5 first fill lands in an empty buffer
    fill(64'h1000, V | 64'h11);
    look(64'h1000, 64'h1000, "R5 fill visible to query");
    look(64'h2000, 64'h0, "R9 query miss returns zero");
    for (int i = 1; i < 64; i++) fill(64'h100 + 64'(i), V);
    look(64'h13F, 64'h13F, "R5 last free entry filled");

    // R8 indexed writes punch holes and lock entry 0
    idx_put(10, 64'hAAAA, 64'h0);
    idx_put(20, 64'hBBBB, 64'h0);
    idx_put(0, 64'h9000, V | L);
    look(64'hAAAA, 64'h0, "R9 invalid entry never matches");
    look(64'h10A, 64'h0, "R8 indexed write replaced entry 10");
    look(64'h9000, 64'h9000, "R8 indexed write at entry 0");
    look(64'h1000, 64'h0, "R8 old entry 0 tag gone");

    // R5 holes refilled, then R6 lowest unlocked replaced
    fill(64'h5000, V);
    fill(64'h6000, V);
    fill(64'h7000, V);
    look(64'h5000, 64'h5000, "R5 first hole filled");
    look(64'h6000, 64'h6000, "R5 second hole filled");
    look(64'h101, 64'h0, "R6 lowest unlocked entry 1 replaced");
    look(64'h7000, 64'h7000, "R6 replacement tag present");
    look(64'h102, 64'h102, "R6 entry 2 untouched");
    look(64'h9000, 64'h9000, "R6 locked entry 0 kept");

    // R7 everything valid and locked: fill dropped
    for (int i = 0; i < 64; i++) idx_put(i, 64'hC000 + 64'(i), V | L | 64'(i));
    fill(64'hDEAD, V);
    look(64'hDEAD, 64'h0, "R7 fill into locked buffer dropped");
    look(64'hC000, 64'hC000, "R7 entry 0 intact");
    look(64'hC01F, 64'hC01F, "R7 entry 31 intact");
    look(64'hC03F, 64'hC03F, "R8 top index 63 written");

    // R10 flush
    wr(C_FLUSH, 64'h0);
    look(64'hC000, 64'h0, "R10 flush clears entry 0");
    look(64'hC03F, 64'h0, "R10 flush clears entry 63");
    fill(64'hE000, V);
    look(64'hE000, 64'hE000, "R10 fill after flush");

    // R11 enable register
    wr(C_CTL_WR, 64'hFF);
    look(64'hE000, 64'h0, "R11 enable change invalidates");
    rd(C_CTL_RD, 64'h3, "R11 enable keeps bits 1:0");
    fill(64'hE100, V);
    wr(C_CTL_WR, 64'h7);
    look(64'hE100, 64'hE100, "R11 equal enable value keeps entries");
    wr(C_CTL_WR, 64'h1);
    look(64'hE100, 64'h0, "R11 differing enable value invalidates");
    rd(C_CTL_RD, 64'h1, "R11 enable readback");
    fill(64'hE100, V);

    // R12 status register
    wr(C_STS_WR, 64'h55);
    rd(C_STS_RD, 64'h55, "R12 status write with bit 0 set");
    wr(C_STS_WR, 64'hF0);
    rd(C_STS_RD, 64'h0, "R12 status write with bit 0 clear");

    // R3 privilege gate
    cur_priv = 1'b0; cur_space = 8'h10;
    issue(C_TAG_WR, 64'h4444, 16'h0, 64'h0, 1'b1, "R3 unprivileged write faults");
    issue(C_TAG_RD, 64'h0, 16'h0, 64'h0, 1'b1, "R3 unprivileged read faults");
    cur_space = 8'h80;
    rd(C_TAG_RD, 64'hE100, "R3 space 0x80 open and tag unchanged");
    cur_space = 8'h7F;
    issue(C_FLUSH, 64'h0, 16'h0, 64'h0, 1'b1, "R3 space 0x7F flush faults");
    cur_priv = 1'b1; cur_space = 8'h58;
    look(64'hE100, 64'hE100, "R3 refused flush had no effect");

    // R2 unused operation code
    issue(4'hF, 64'hFFFF, 16'h0, 64'h0, 1'b0, "R2 unused code returns zero");
    look(64'hE100, 64'hE100, "R2 unused code changed nothing");
    idle();
    repeat (3) @(negedge clk);

    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R2 responses missing: %0d outstanding expected 0", q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule